// File: doc/BRIEF.md
# Multi-Function Pin Bank Controller

The block drives and watches a bank of general-purpose pins (sixteen by default). Software programs it through a simple word-addressed register bus. Each pin has its own configuration byte, which selects:

- the driver style;
- the source of the output data;
- the pull resistors;
- an interrupt trigger;
- a wake-up polarity.

Incoming pad values pass through a two-flop synchronizer. Software can read them, and they feed both a sticky, maskable interrupt and a level-only wake-up request.

The output data of a pin comes either from a software data bit or from a shared first-order sigma-delta modulator. The modulator has an 8-bit density value and a clock prescaler. A per-pin hold bit freezes the pad drive registers at their present state. A park input forces every output enable low while the chip is being powered down.

Top module: `pinbank_ctrl`

## Requirements

- R1: After reset, every register reads 0 and pad_out, pad_oe, irq and wake are all low.
- R2: A push-pull pin (config bit 0 = 0) has pad_out equal to its data bit (register 0x00) and pad_oe equal to its enable bit (register 0x01). Both pads follow the second rising edge after the write. Register 0x00 reads back the written data.
- R3: An open-drain pin (config bit 0 = 1) never drives high. pad_out is 0 and pad_oe equals enable AND NOT data.
- R4: pad_pu and pad_pd of each pin mirror its config bit 2 and config bit 3. The per-pin config bytes are at word addresses 0x10+pin.
- R5: Register 0x02 returns pad_in after a two-flop synchronizer. A pad change becomes readable with a read issued two cycles after the change.
- R6: Trigger field config[6:4] value 0 sets the status bit on a rising edge, 1 on a falling edge and 2 on either edge. The status bit is set on the third rising edge after the pad change. irq is high whenever any status bit (register 0x03) is set with its enable bit (register 0x04) set.
- R7: Trigger value 3 sets status while the pin is high and value 4 while it is low. Values 5 to 7 never set status.
- R8: Status bits are sticky. Writing 1 to a bit of register 0x03 clears it, writing 0 leaves it unchanged, and an active level condition re-sets the bit at once.
- R9: wake is high while any pin enabled in register 0x05 has a synchronized level equal to its config bit 7 (1 = high). It is not latched.
- R10: With density D (register 0x07 bits [7:0]), the modulator output is 1 on exactly D of every 256 modulator ticks. A pin with config bit 1 set takes the modulator output as its data.
- R11: With prescaler P (register 0x07 bits [23:8]), the modulator ticks once every P+1 clock cycles.
- R12: While a pin's hold bit (register 0x06) is set, its pad_out and its registered output enable keep the value they had when the hold bit was set, whatever is written meanwhile.
- R13: While park is high, pad_oe is 0 on every pin in the same cycle. When park is released, the previous enables return.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears after the next edge |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output data |
| pad_oe | output | 16 | Pad output enables |
| pad_pu | output | 16 | Pull-up enables |
| pad_pd | output | 16 | Pull-down enables |
| park | input | 1 | Power-down request; forces all output enables low |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Level wake-up request |

## Verification

A wrong synchronizer or edge register shows at the ports in two ways:

- a status bit that sets one cycle early or late;
- a trigger that answers the wrong edge direction.

The bench checks both at the exact cycle on irq and by read-back of register 0x03. A corrupted modulator accumulator or prescaler counter changes the count of ones and transitions on a modulated pin within a 256-cycle window. A hold or park fault shows on pad_out or pad_oe within one cycle of the write or the park change.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int unsigned ADDR_W = 6;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_DATA  = 6'h00;
    localparam logic [ADDR_W-1:0] A_OEN   = 6'h01;
    localparam logic [ADDR_W-1:0] A_PINS  = 6'h02;
    localparam logic [ADDR_W-1:0] A_STAT  = 6'h03;
    localparam logic [ADDR_W-1:0] A_IEN   = 6'h04;
    localparam logic [ADDR_W-1:0] A_WEN   = 6'h05;
    localparam logic [ADDR_W-1:0] A_HOLD  = 6'h06;
    localparam logic [ADDR_W-1:0] A_MOD   = 6'h07;
    localparam logic [1:0]        A_CFG_HI = 2'b01;

    typedef enum logic [2:0] {
        TRIG_RISE  = 3'd0,
        TRIG_FALL  = 3'd1,
        TRIG_BOTH  = 3'd2,
        TRIG_HIGH  = 3'd3,
        TRIG_LOW   = 3'd4,
        TRIG_OFF5  = 3'd5,
        TRIG_OFF6  = 3'd6,
        TRIG_OFF7  = 3'd7
    } trig_e;

    typedef struct packed {
        logic  wake_hi;     // bit 7
        trig_e trig;        // bits 6:4
        logic  pull_dn;     // bit 3
        logic  pull_up;     // bit 2
        logic  use_mod;     // bit 1
        logic  open_drain;  // bit 0
    } pin_cfg_t;

    typedef struct packed {
        logic oe;
        logic out;
    } pad_drv_t;

    function automatic logic trig_hit(trig_e mode, logic cur, logic prv);
        case (mode)
            TRIG_RISE: return cur & ~prv;
            TRIG_FALL: return ~cur & prv;
            TRIG_BOTH: return cur ^ prv;
            TRIG_HIGH: return cur;
            TRIG_LOW:  return ~cur;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic pad_drv_t pad_drive(logic od, logic en, logic dat);
        pad_drv_t r;
        if (od) begin
            r.out = 1'b0;
            r.oe  = en & ~dat;
        end else begin
            r.out = dat;
            r.oe  = en;
        end
        return r;
    endfunction

endpackage

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int unsigned NPINS   = 16,
    parameter int unsigned DENS_W  = 8,
    parameter int unsigned PRESC_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [NPINS-1:0]         pin_sync,
    input  logic [NPINS-1:0]         stat_set,
    output logic [NPINS-1:0]         data_q,
    output logic [NPINS-1:0]         oen_q,
    output logic [NPINS-1:0]         ien_q,
    output logic [NPINS-1:0]         wen_q,
    output logic [NPINS-1:0]         hold_q,
    output logic [NPINS-1:0]         stat_q,
    output logic [DENS_W-1:0]        dens_q,
    output logic [PRESC_W-1:0]       presc_q,
    output pin_cfg_t [NPINS-1:0]     cfg_q
);
    localparam int unsigned CFG_W = $bits(pin_cfg_t);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic              is_cfg;
    logic [IDX_W-1:0]  cfg_idx;
    logic [NPINS-1:0]  clr_mask;
    logic [DATA_W-1:0] rd_mux;

    assign cfg_idx  = bus_addr[IDX_W-1:0];
    assign is_cfg   = (bus_addr[ADDR_W-1:IDX_W] == A_CFG_HI) && (int'(cfg_idx) < NPINS);
    assign clr_mask = (bus_wr && bus_addr == A_STAT) ? bus_wdata[NPINS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            oen_q   <= '0;
            ien_q   <= '0;
            wen_q   <= '0;
            hold_q  <= '0;
            dens_q  <= '0;
            presc_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_DATA: data_q  <= bus_wdata[NPINS-1:0];
                A_OEN:  oen_q   <= bus_wdata[NPINS-1:0];
                A_IEN:  ien_q   <= bus_wdata[NPINS-1:0];
                A_WEN:  wen_q   <= bus_wdata[NPINS-1:0];
                A_HOLD: hold_q  <= bus_wdata[NPINS-1:0];
                A_MOD: begin
                    dens_q  <= bus_wdata[DENS_W-1:0];
                    presc_q <= bus_wdata[DENS_W +: PRESC_W];
                end
                default: ;
            endcase
        end
    end

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_cfg
            always_ff @(posedge clk) begin
                if (rst) begin
                    cfg_q[p] <= '0;
                end else if (bus_wr && is_cfg && int'(cfg_idx) == p) begin
                    cfg_q[p] <= pin_cfg_t'(bus_wdata[CFG_W-1:0]);
                end
            end
        end
    endgenerate

    // sticky status: new events win over a simultaneous clear
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr_mask) | stat_set;
    end

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_DATA: rd_mux[NPINS-1:0] = data_q;
            A_OEN:  rd_mux[NPINS-1:0] = oen_q;
            A_PINS: rd_mux[NPINS-1:0] = pin_sync;
            A_STAT: rd_mux[NPINS-1:0] = stat_q;
            A_IEN:  rd_mux[NPINS-1:0] = ien_q;
            A_WEN:  rd_mux[NPINS-1:0] = wen_q;
            A_HOLD: rd_mux[NPINS-1:0] = hold_q;
            A_MOD:  rd_mux[DENS_W+PRESC_W-1:0] = {presc_q, dens_q};
            default: if (is_cfg) rd_mux[CFG_W-1:0] = cfg_q[cfg_idx];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/pinbank_mod.sv
module pinbank_mod #(
    parameter int unsigned DENS_W  = 8,
    parameter int unsigned PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DENS_W-1:0]  dens,
    input  logic [PRESC_W-1:0] presc,
    output logic               mod_bit
);
    logic [PRESC_W-1:0] div_cnt;
    logic [DENS_W-1:0]  acc;
    logic [DENS_W:0]    sum;
    logic               tick;

    // >= keeps the divider sane if the limit is lowered mid-count
    assign tick = (div_cnt >= presc);
    assign sum  = {1'b0, acc} + {1'b0, dens};

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            acc     <= '0;
            mod_bit <= 1'b0;
        end else if (tick) begin
            div_cnt <= '0;
            acc     <= sum[DENS_W-1:0];
            mod_bit <= sum[DENS_W];
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pinbank_inpath.sv
module pinbank_inpath
    import pinbank_pkg::*;
#(
    parameter int unsigned NPINS = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NPINS-1:0]     pad_in,
    input  pin_cfg_t [NPINS-1:0] cfg,
    input  logic [NPINS-1:0]     wen,
    output logic [NPINS-1:0]     pin_sync,
    output logic [NPINS-1:0]     stat_set,
    output logic                 wake
);
    logic [NPINS-1:0] meta_q;
    logic [NPINS-1:0] sync_q;
    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] wake_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_det
            assign stat_set[p] = trig_hit(cfg[p].trig, sync_q[p], prev_q[p]);
            assign wake_hit[p] = wen[p] & (sync_q[p] == cfg[p].wake_hi);
        end
    endgenerate

    assign pin_sync = sync_q;
    assign wake     = |wake_hit;

endmodule

// File: rtl/pinbank_drive.sv
module pinbank_drive
    import pinbank_pkg::*;
#(
    parameter int unsigned NPINS = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  pin_cfg_t [NPINS-1:0] cfg,
    input  logic [NPINS-1:0]     data,
    input  logic [NPINS-1:0]     oen,
    input  logic [NPINS-1:0]     hold,
    input  logic                 mod_bit,
    input  logic                 park,
    output logic [NPINS-1:0]     pad_out,
    output logic [NPINS-1:0]     pad_oe,
    output logic [NPINS-1:0]     pad_pu,
    output logic [NPINS-1:0]     pad_pd
);
    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_pin
            logic     src_bit;
            pad_drv_t nxt;
            pad_drv_t cur_q;

            always_comb begin
                src_bit = cfg[p].use_mod ? mod_bit : data[p];
                nxt     = pad_drive(cfg[p].open_drain, oen[p], src_bit);
            end

            always_ff @(posedge clk) begin
                if (rst)          cur_q <= '0;
                else if (!hold[p]) cur_q <= nxt;
            end

            assign pad_out[p] = cur_q.out;
            assign pad_oe[p]  = cur_q.oe & ~park;
            assign pad_pu[p]  = cfg[p].pull_up;
            assign pad_pd[p]  = cfg[p].pull_dn;
        end
    endgenerate

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int unsigned NPINS   = 16,
    parameter int unsigned DENS_W  = 8,
    parameter int unsigned PRESC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [5:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pu,
    output logic [NPINS-1:0]  pad_pd,
    input  logic              park,
    output logic              irq,
    output logic              wake
);
    logic [NPINS-1:0]   data_v, oen_v, ien_v, wen_v, hold_v, stat_v;
    logic [NPINS-1:0]   sync_v, set_v, od_v;
    logic [DENS_W-1:0]  dens_v;
    logic [PRESC_W-1:0] presc_v;
    pin_cfg_t [NPINS-1:0] cfg_v;
    logic               mod_v;
    logic               stat_wr_v;

    pinbank_regs #(.NPINS(NPINS), .DENS_W(DENS_W), .PRESC_W(PRESC_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_sync(sync_v), .stat_set(set_v),
        .data_q(data_v), .oen_q(oen_v), .ien_q(ien_v), .wen_q(wen_v),
        .hold_q(hold_v), .stat_q(stat_v),
        .dens_q(dens_v), .presc_q(presc_v), .cfg_q(cfg_v)
    );

    pinbank_mod #(.DENS_W(DENS_W), .PRESC_W(PRESC_W)) u_mod (
        .clk(clk), .rst(rst), .dens(dens_v), .presc(presc_v), .mod_bit(mod_v)
    );

    pinbank_inpath #(.NPINS(NPINS)) u_in (
        .clk(clk), .rst(rst), .pad_in(pad_in), .cfg(cfg_v), .wen(wen_v),
        .pin_sync(sync_v), .stat_set(set_v), .wake(wake)
    );

    pinbank_drive #(.NPINS(NPINS)) u_drv (
        .clk(clk), .rst(rst), .cfg(cfg_v), .data(data_v), .oen(oen_v),
        .hold(hold_v), .mod_bit(mod_v), .park(park),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_od
            assign od_v[p] = cfg_v[p].open_drain;
        end
    endgenerate

    assign stat_wr_v = bus_wr && (bus_addr == A_STAT);
    assign irq       = |(stat_v & ien_v);

endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk #(
    parameter int unsigned NPINS = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic             park,
    input logic             irq,
    input logic             wake,
    input logic [NPINS-1:0] hold,
    input logic [NPINS-1:0] stat,
    input logic [NPINS-1:0] ien,
    input logic [NPINS-1:0] wen,
    input logic [NPINS-1:0] od_mask,
    input logic             stat_wr
);
    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & pad_out & od_mask & $past(od_mask)) == '0)); // R3

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (ien == '0) |-> !irq); // R6

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (rst)
        !$past(stat_wr) |-> (($past(stat) & ~stat) == '0)); // R8

    AST_WAKE_MASKED: assert property (@(posedge clk) disable iff (rst)
        (wen == '0) |-> !wake); // R9

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (((pad_out ^ $past(pad_out)) & hold & $past(hold)) == '0)); // R12

    AST_PARK_OE_LOW: assert property (@(posedge clk) disable iff (rst)
        park |-> (pad_oe == '0)); // R13

endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst(rst), .pad_out(pad_out), .pad_oe(pad_oe), .park(park),
    .irq(irq), .wake(wake), .hold(hold_v), .stat(stat_v), .ien(ien_v),
    .wen(wen_v), .od_mask(od_v), .stat_wr(stat_wr_v)
);

// File: tb/tb_pinbank_ctrl.sv
`timescale 1ns/1ps
module tb_pinbank_ctrl;
    localparam int N = 16;
    localparam logic [5:0] R_DATA = 6'h00, R_OEN = 6'h01, R_PINS = 6'h02, R_STAT = 6'h03,
                           R_IEN = 6'h04, R_WEN = 6'h05, R_HOLD = 6'h06, R_MOD = 6'h07,
                           R_CFG = 6'h10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out, pad_oe, pad_pu, pad_pd;
    logic park = 1'b0;
    logic irq, wake;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] exp_val_q[$];
    string       exp_tag_q[$];

    always #2.5 clk = ~clk;

    pinbank_ctrl dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .park(park), .irq(irq), .wake(wake)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver tasks: called at a falling edge, return at the next one
    task automatic wr(logic [5:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
        bus_rd = 1'b1; bus_addr = a;
        exp_val_q.push_back(exp);
        exp_tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor: compare read data against the scoreboard queue
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                #1;
                if (exp_val_q.size() == 0) begin
                    check("read with empty queue", 32'h1, 32'h0);
                end else begin
                    check(exp_tag_q.pop_front(), bus_rdata, exp_val_q.pop_front());
                end
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    task automatic count_mod(output int ones, output int flips);
        logic prv;
        ones = 0; flips = 0;
        prv = pad_out[7];
        for (int i = 0; i < 256; i++) begin
            if (pad_out[7]) ones++;
            @(negedge clk);
            if (pad_out[7] != prv) flips++;
            prv = pad_out[7];
        end
    endtask

    initial begin
        int ones, flips;
        idle(4);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 pad_oe", 32'(pad_oe), 32'h0);
        check("R1 pad_out", 32'(pad_out), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 wake", 32'(wake), 32'h0);
        rd(R_DATA, 32'h0, "R1 data reg");
        rd(R_MOD, 32'h0, "R1 mod reg");
        rd(R_CFG, 32'h0, "R1 cfg0 reg");

        // R2 push-pull
        wr(R_OEN, 32'hFFFF);
        wr(R_DATA, 32'hA5C3);
        idle(1);
        check("R2 oe", 32'(pad_oe), 32'hFFFF);
        check("R2 out", 32'(pad_out), 32'hA5C3);
        wr(R_DATA, 32'h5A3C);
        idle(1);
        check("R2 out2", 32'(pad_out), 32'h5A3C);
        rd(R_DATA, 32'h5A3C, "R2 readback");

        // R3 open-drain on pins 0..3 (data nibble 1100)
        for (int p = 0; p < 4; p++) wr(R_CFG + 6'(p), 32'h01);
        idle(1);
        check("R3 oe", 32'(pad_oe), 32'hFFF3);
        check("R3 out", 32'(pad_out), 32'h5A30);

        // R4 pulls
        wr(R_CFG + 6'd5, 32'h04);
        wr(R_CFG + 6'd6, 32'h08);
        #1;
        check("R4 pu", 32'(pad_pu), 32'h0020);
        check("R4 pd", 32'(pad_pd), 32'h0040);

        // R5 synchronized input read
        pad_in = 16'h1234;
        rd(R_PINS, 32'h0, "R5 first cycle");
        rd(R_PINS, 32'h0, "R5 second cycle");
        rd(R_PINS, 32'h1234, "R5 third cycle");

        // R6 edge triggers
        pad_in = 16'h0000;
        idle(4);
        wr(R_STAT, 32'hFFFF);
        rd(R_STAT, 32'h0, "R8 cleared");
        wr(R_CFG + 6'd8, 32'h00);
        wr(R_CFG + 6'd9, 32'h10);
        wr(R_CFG + 6'd10, 32'h20);
        wr(R_IEN, 32'h0700);
        pad_in = 16'h0100;
        idle(2);
        check("R6 irq not yet", 32'(irq), 32'h0);
        idle(1);
        check("R6 irq on third edge", 32'(irq), 32'h1);
        rd(R_STAT, 32'h0100, "R6 rise");
        pad_in = 16'h0300;
        idle(4);
        rd(R_STAT, 32'h0100, "R6 fall pin ignores rise");
        pad_in = 16'h0000;
        idle(4);
        rd(R_STAT, 32'h0300, "R6 fall");
        pad_in = 16'h0400;
        idle(4);
        rd(R_STAT, 32'h0700, "R6 both rise");
        wr(R_STAT, 32'h0400);
        rd(R_STAT, 32'h0300, "R8 w1c single bit");
        pad_in = 16'h0000;
        idle(4);
        rd(R_STAT, 32'h0700, "R6 both fall");
        wr(R_IEN, 32'h0000);
        check("R6 irq masked", 32'(irq), 32'h0);
        wr(R_IEN, 32'h0200);
        check("R6 irq enabled", 32'(irq), 32'h1);
        wr(R_IEN, 32'h0000);

        // R7 level triggers
        wr(R_CFG + 6'd11, 32'h30);
        wr(R_CFG + 6'd12, 32'h40);
        wr(R_CFG + 6'd13, 32'h50);
        wr(R_STAT, 32'hFFFF);
        idle(2);
        rd(R_STAT, 32'h1000, "R7 low level re-sets after clear R8");
        pad_in = 16'h3800;
        idle(4);
        wr(R_STAT, 32'hFFFF);
        idle(2);
        rd(R_STAT, 32'h0800, "R7 high level only");

        // R9 wake
        wr(R_CFG + 6'd14, 32'hD0);
        wr(R_CFG + 6'd15, 32'h50);
        wr(R_WEN, 32'h4000);
        check("R9 wake idle", 32'(wake), 32'h0);
        pad_in = 16'h7800;
        idle(1);
        check("R9 wake before sync", 32'(wake), 32'h0);
        idle(1);
        check("R9 wake high", 32'(wake), 32'h1);
        pad_in = 16'h3800;
        idle(2);
        check("R9 wake not latched", 32'(wake), 32'h0);
        wr(R_WEN, 32'hC000);
        check("R9 wake low polarity", 32'(wake), 32'h1);
        wr(R_WEN, 32'h0000);

        // R10 modulator density
        wr(R_CFG + 6'd7, 32'h52);
        wr(R_MOD, 32'd64);
        idle(20);
        count_mod(ones, flips);
        check("R10 density 64", 32'(ones), 32'd64);
        wr(R_MOD, 32'd0);
        idle(20);
        count_mod(ones, flips);
        check("R10 density 0", 32'(ones), 32'd0);
        wr(R_MOD, 32'd255);
        idle(20);
        count_mod(ones, flips);
        check("R10 density 255", 32'(ones), 32'd255);

        // R11 prescaler
        wr(R_MOD, 32'd128);
        idle(20);
        count_mod(ones, flips);
        check("R11 div1 flips", 32'(flips), 32'd256);
        wr(R_MOD, (32'd3 << 8) | 32'd128);
        idle(20);
        count_mod(ones, flips);
        check("R11 div4 ones", 32'(ones), 32'd128);
        check("R11 div4 flips", 32'(flips), 32'd64);

        // R12 hold on pins 8..11
        wr(R_HOLD, 32'h0F00);
        wr(R_DATA, 32'h0000);
        wr(R_OEN, 32'h00FF);
        idle(1);
        check("R12 held out", 32'(pad_out & 16'hFF00), 32'h0A00);
        check("R12 held oe", 32'(pad_oe & 16'hFF00), 32'h0F00);
        wr(R_HOLD, 32'h0000);
        idle(1);
        check("R12 released out", 32'(pad_out & 16'hFF00), 32'h0000);
        check("R12 released oe", 32'(pad_oe & 16'hFF00), 32'h0000);

        // R13 park
        wr(R_OEN, 32'hFFFF);
        idle(1);
        park = 1'b1;
        #1;
        check("R13 park same cycle", 32'(pad_oe), 32'h0);
        @(negedge clk);
        check("R13 park held", 32'(pad_oe), 32'h0);
        park = 1'b0;
        #1;
        check("R13 unpark", 32'(pad_oe), 32'hFFFF);

        idle(3);
        check("queue drained", 32'(exp_val_q.size()), 32'h0);
        finish_run();
    end

endmodule